// File: doc/BRIEF.md
# ATA PIO Timing Parameter Calculator

The block turns a requested ATA PIO mode and the bus clock rate, given in MHz, into four cycle-count timing parameters for one drive. It then emits them as a short register-write sequence into a timing register file. The sequence opens register access, makes four writes and closes access again. An internal table supplies the active-pulse time and the full cycle time of each mode in nanoseconds. Each time is scaled to bus cycles and rounded up.

A controller pulses `start_i` with the mode, the clock rate, the channel and the unit selected. It then follows the strobes on the write outputs until `done_o` pulses. A mode the table does not cover raises `err_o` and produces no writes. A new request is accepted only when the block is idle.

Top module: `ata_pio_timing_calc`

## Requirements
- R1: After reset, `acc_open_o`, `wr_en_o`, `acc_close_o`, `done_o` and `err_o` are all low, and they stay low until a start is accepted.
- R2: The active count is (A × F + 999) / 1000 in integer arithmetic, truncated to 8 bits. F is `bus_mhz_i` and A is the active time in ns. A is 165, 125, 100, 80 and 70 for modes 0 to 4.
- R3: The recovery count is (C × F + 999) / 1000 minus the active count, truncated to 8 bits. C is the cycle time in ns: 600, 383, 240, 180 and 120 for modes 0 to 4.
- R4: Parameter slots 2 and 3 repeat the active and recovery counts. For modes 0, 1 and 2 each gets 8 added, modulo 256. For modes 3 and 4 they are plain copies.
- R5: Every write index equals drive × 4 + slot. The drive is `chan_i` × 2 + `unit_i`. Slots go out in the order 0 (active), 1 (recovery), 2 (padded active), 3 (padded recovery).
- R6: A start accepted at a clock edge gives the following one-cycle strobes. `acc_open_o` is high in the next cycle. `wr_en_o` is high in the four cycles after that, for slots 0 to 3. `acc_close_o` follows in the next cycle, then `done_o` in the cycle after. The block is idle again after that.
- R7: A start with a mode of 5, 6 or 7 pulses `err_o` in the next cycle and produces no open, write, close or done strobe.
- R8: A start that arrives while a sequence is running has no effect. The running sequence keeps its latched parameters and no second sequence follows it.
- R9: At most one of `acc_open_o`, `wr_en_o`, `acc_close_o`, `done_o` and `err_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| pio_mode_i | input | 3 | Requested PIO mode |
| bus_mhz_i | input | 8 | Bus clock rate in MHz |
| chan_i | input | 1 | Channel index |
| unit_i | input | 1 | Drive unit on the channel |
| acc_open_o | output | 1 | Open register access strobe |
| wr_en_o | output | 1 | Register write strobe |
| wr_idx_o | output | 8 | Register index of the write |
| wr_data_o | output | 8 | Register data of the write |
| acc_close_o | output | 1 | Close register access strobe |
| done_o | output | 1 | Sequence complete strobe |
| err_o | output | 1 | Unsupported mode strobe |

## Verification
A wrong sequencer state shows at the ports within one cycle. It appears as a strobe in the wrong cycle, two strobes at once, or a write index whose slot does not step by one. A stale or corrupted latch of the request shows in the first data write, four cycles after it should have appeared. The bench therefore compares the exact per-cycle strobe pattern and all four data values of every request, including requests sent while a sequence is running.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int NS_W   = 10;
  localparam int MODE_W = 3;
  localparam int NSLOT  = 4;
  localparam int PAD    = 8;
  localparam int SLOW_MODES = 3;  // modes below this get the pad
  localparam int MAX_MODE   = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_OPEN, S_WR, S_CLOSE, S_DONE
  } seq_state_e;

  function automatic logic [NS_W-1:0] act_ns(input logic [MODE_W-1:0] m);
    case (m)
      3'd0: act_ns = 10'd165;
      3'd1: act_ns = 10'd125;
      3'd2: act_ns = 10'd100;
      3'd3: act_ns = 10'd80;
      3'd4: act_ns = 10'd70;
      default: act_ns = '0;
    endcase
  endfunction

  function automatic logic [NS_W-1:0] cyc_ns(input logic [MODE_W-1:0] m);
    case (m)
      3'd0: cyc_ns = 10'd600;
      3'd1: cyc_ns = 10'd383;
      3'd2: cyc_ns = 10'd240;
      3'd3: cyc_ns = 10'd180;
      3'd4: cyc_ns = 10'd120;
      default: cyc_ns = '0;
    endcase
  endfunction
endpackage

// File: rtl/pio_time_lut.sv
module pio_time_lut
  import ata_pio_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output logic [NS_W-1:0]   act_ns_o,
  output logic [NS_W-1:0]   cyc_ns_o,
  output logic              valid_o
);
  always_comb begin
    act_ns_o = act_ns(mode_i);
    cyc_ns_o = cyc_ns(mode_i);
    valid_o  = (int'(mode_i) <= MAX_MODE);
  end
endmodule

// File: rtl/pio_cycle_div.sv
module pio_cycle_div #(
  parameter int NS_W  = 10,
  parameter int MHZ_W = 8,
  localparam int Q_W  = NS_W + MHZ_W + 1
) (
  input  logic [NS_W-1:0]  ns_i,
  input  logic [MHZ_W-1:0] mhz_i,
  output logic [Q_W-1:0]   cycles_o
);
  logic [Q_W-1:0] prod;
  always_comb begin
    prod     = Q_W'(ns_i) * Q_W'(mhz_i) + Q_W'(999);
    cycles_o = prod / Q_W'(1000);  // ceil(ns * MHz / 1000)
  end
endmodule

// File: rtl/pio_param_pack.sv
module pio_param_pack
  import ata_pio_pkg::*;
#(
  parameter int Q_W   = 19,
  parameter int PRM_W = 8
) (
  input  logic [Q_W-1:0]                act_cyc_i,
  input  logic [Q_W-1:0]                tot_cyc_i,
  input  logic [MODE_W-1:0]             mode_i,
  output logic [NSLOT-1:0][PRM_W-1:0]   prm_o
);
  logic [PRM_W-1:0] act_p, rec_p;
  logic             slow;

  always_comb begin
    act_p = act_cyc_i[PRM_W-1:0];
    rec_p = PRM_W'(tot_cyc_i - act_cyc_i);
    slow  = (int'(mode_i) < SLOW_MODES);
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [PRM_W-1:0] base;
    assign base = (s % 2 == 0) ? act_p : rec_p;
    if (s >= 2) begin : g_pad
      assign prm_o[s] = slow ? base + PRM_W'(PAD) : base;
    end else begin : g_raw
      assign prm_o[s] = base;
    end
  end
endmodule

// File: rtl/pio_wr_seq.sv
module pio_wr_seq
  import ata_pio_pkg::*;
#(
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  output logic              idle_o,
  output logic              open_o,
  output logic              wr_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              close_o,
  output logic              done_o
);
  seq_state_e       state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    case (state_q)
      S_IDLE:  if (go_i) state_d = S_OPEN;
      S_OPEN:  begin state_d = S_WR; slot_d = '0; end
      S_WR: begin
        if (slot_q == SLOT_W'(NSLOT-1)) state_d = S_CLOSE;
        else slot_d = slot_q + 1'b1;
      end
      S_CLOSE: state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
    end
  end

  assign idle_o  = (state_q == S_IDLE);
  assign open_o  = (state_q == S_OPEN);
  assign wr_o    = (state_q == S_WR);
  assign slot_o  = slot_q;
  assign close_o = (state_q == S_CLOSE);
  assign done_o  = (state_q == S_DONE);
endmodule

// File: rtl/ata_pio_timing_calc.sv
module ata_pio_timing_calc
  import ata_pio_pkg::*;
#(
  parameter int MHZ_W  = 8,
  parameter int CHAN_W = 1,
  parameter int IDX_W  = 8,
  parameter int PRM_W  = 8,
  localparam int DRV_W  = CHAN_W + 1,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int Q_W    = NS_W + MHZ_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        pio_mode_i,
  input  logic [MHZ_W-1:0]  bus_mhz_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              unit_i,
  output logic              acc_open_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [PRM_W-1:0]  wr_data_o,
  output logic              acc_close_o,
  output logic              done_o,
  output logic              err_o
);
  logic [MODE_W-1:0] mode_q;
  logic [MHZ_W-1:0]  mhz_q;
  logic [DRV_W-1:0]  drv_q;
  logic              err_q;
  logic              idle, mode_ok, accept;
  logic [NS_W-1:0]   a_ns, c_ns;
  logic [Q_W-1:0]    a_cyc, c_cyc;
  logic [NSLOT-1:0][PRM_W-1:0] prm;
  logic [SLOT_W-1:0] slot;

  // validity judged on the live request, timing on the latched one
  logic [NS_W-1:0] unused_a, unused_c;
  pio_time_lut u_chk_lut (
    .mode_i(pio_mode_i), .act_ns_o(unused_a), .cyc_ns_o(unused_c), .valid_o(mode_ok)
  );

  assign accept = start_i && idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      mhz_q  <= '0;
      drv_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= accept && !mode_ok;
      if (accept && mode_ok) begin
        mode_q <= pio_mode_i;
        mhz_q  <= bus_mhz_i;
        drv_q  <= {chan_i, unit_i};
      end
    end
  end

  logic lut_ok_q;
  pio_time_lut u_lut (
    .mode_i(mode_q), .act_ns_o(a_ns), .cyc_ns_o(c_ns), .valid_o(lut_ok_q)
  );

  pio_cycle_div #(.NS_W(NS_W), .MHZ_W(MHZ_W)) u_div_act (
    .ns_i(a_ns), .mhz_i(mhz_q), .cycles_o(a_cyc)
  );
  pio_cycle_div #(.NS_W(NS_W), .MHZ_W(MHZ_W)) u_div_cyc (
    .ns_i(c_ns), .mhz_i(mhz_q), .cycles_o(c_cyc)
  );

  pio_param_pack #(.Q_W(Q_W), .PRM_W(PRM_W)) u_pack (
    .act_cyc_i(a_cyc), .tot_cyc_i(c_cyc), .mode_i(mode_q), .prm_o(prm)
  );

  pio_wr_seq u_seq (
    .clk_i, .rst_ni, .go_i(accept && mode_ok), .idle_o(idle),
    .open_o(acc_open_o), .wr_o(wr_en_o), .slot_o(slot),
    .close_o(acc_close_o), .done_o(done_o)
  );

  assign wr_idx_o  = IDX_W'({drv_q, slot});
  assign wr_data_o = prm[slot];
  assign err_o     = err_q;

  logic unused_ok;
  assign unused_ok = ^{unused_a, unused_c, lut_ok_q};
endmodule

// File: rtl/pio_timing_chk.sv
module pio_timing_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_open_o,
  input logic             wr_en_o,
  input logic [IDX_W-1:0] wr_idx_o,
  input logic             acc_close_o,
  input logic             done_o,
  input logic             err_o
);
  p_one_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acc_open_o, wr_en_o, acc_close_o, done_o, err_o}));

  p_open_then_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_open_o |=> (wr_en_o && wr_idx_o[1:0] == 2'd0));

  p_close_then_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_close_o |=> done_o);

  p_slot_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_idx_o[1:0] != 2'd3) |=>
      (wr_en_o && wr_idx_o == $past(wr_idx_o) + 1'b1));

  p_last_slot_close_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_idx_o[1:0] == 2'd3) |=> acc_close_o);

  p_err_no_open_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !acc_open_o);
endmodule

bind ata_pio_timing_calc pio_timing_chk #(.IDX_W(IDX_W)) u_pio_timing_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .acc_open_o(acc_open_o), .wr_en_o(wr_en_o),
  .wr_idx_o(wr_idx_o), .acc_close_o(acc_close_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/tb_ata_pio_timing_calc.sv
module tb_ata_pio_timing_calc;
  logic       clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [2:0] pio_mode_i = '0;
  logic [7:0] bus_mhz_i = '0;
  logic       chan_i = 1'b0, unit_i = 1'b0;
  logic       acc_open_o, wr_en_o, acc_close_o, done_o, err_o;
  logic [7:0] wr_idx_o, wr_data_o;

  int errors = 0, checks = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  ata_pio_timing_calc dut (.*);

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic int t_act(int m);
    case (m) 0: return 165; 1: return 125; 2: return 100; 3: return 80; default: return 70; endcase
  endfunction
  function automatic int t_cyc(int m);
    case (m) 0: return 600; 1: return 383; 2: return 240; 3: return 180; default: return 120; endcase
  endfunction
  function automatic int exp_prm(int m, int f, int slot);
    int a, c, v;
    a = (t_act(m) * f + 999) / 1000;
    c = (t_cyc(m) * f + 999) / 1000 - a;
    v = (slot % 2 == 0) ? a : c;
    if (slot >= 2 && m < 3) v += 8;
    return v & 255;
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d exp %0d", req, got, exp);
    end
  endtask

  // strobe code per cycle: 1 open, 2 write, 3 close, 4 done, 5 err, 0 none
  function automatic int strobe_code();
    int n;
    n = int'(acc_open_o) + int'(wr_en_o) + int'(acc_close_o) + int'(done_o) + int'(err_o);
    if (n > 1) return 9;
    if (acc_open_o) return 1;
    if (wr_en_o) return 2;
    if (acc_close_o) return 3;
    if (done_o) return 4;
    if (err_o) return 5;
    return 0;
  endfunction

  task automatic run_req(int m, int f, int ch, int un, bit inject);
    int bad_pat = 0, bad_idx = 0;
    pio_mode_i = 3'(m); bus_mhz_i = 8'(f); chan_i = ch[0]; unit_i = un[0];
    start_i = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      int exp_code, code;
      @(negedge clk_i);
      if (m > 4) exp_code = (k == 1) ? 5 : 0;
      else exp_code = (k == 1) ? 1 : (k <= 5) ? 2 : (k == 6) ? 3 : (k == 7) ? 4 : 0;
      code = strobe_code();
      if (code != exp_code) begin
        bad_pat++;
        $display("FAIL %s: cycle %0d strobe got %0d exp %0d",
                 (m > 4) ? "R7" : (inject ? "R8" : "R6"), k, code, exp_code);
      end
      if (code == 2 && m <= 4) begin
        int slot = k - 2;
        if (int'(wr_idx_o) != (ch * 2 + un) * 4 + slot) bad_idx++;
        chk(slot % 2 == 0 ? "R2/R4 active" : "R3/R4 recovery",
            int'(wr_data_o), exp_prm(m, f, slot));
      end
      if (k == 1) start_i = 1'b0;
      if (inject && k == 3) begin
        pio_mode_i = 3'((m + 2) % 5); bus_mhz_i = 8'(f ^ 8'h5a);
        chan_i = ~ch[0]; unit_i = ~un[0]; start_i = 1'b1;
      end
      if (inject && k == 4) start_i = 1'b0;
    end
    chk(inject ? "R8 pattern" : (m > 4 ? "R7 pattern" : "R6 pattern"), bad_pat, 0);
    if (m <= 4) chk("R5 index", bad_idx, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 reset", int'({acc_open_o, wr_en_o, acc_close_o, done_o, err_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 idle", int'({acc_open_o, wr_en_o, acc_close_o, done_o, err_o}), 0);

    // directed corners
    run_req(0, 255, 1, 1, 1'b0);  // R2 43, R3 110, R4 51/118
    run_req(4, 255, 0, 0, 1'b0);  // R4 no pad
    run_req(2, 0, 1, 0, 1'b0);    // R4 zero clock, pad only
    run_req(3, 1, 0, 1, 1'b0);    // R2 rounding of tiny products
    run_req(5, 100, 0, 0, 1'b0);  // R7
    run_req(7, 33, 1, 1, 1'b0);   // R7
    run_req(1, 66, 0, 1, 1'b1);   // R8 start while busy
    run_req(2, 50, 1, 0, 1'b0);   // R9 exclusivity covered in strobe code

    for (int i = 0; i < 40; i++) begin
      run_req(int'($urandom_range(0, 4)), int'($urandom_range(0, 255)),
              int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
              ($urandom_range(0, 3) == 0));
    end
    run_req(6, 200, 0, 1, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule